// File: doc/BRIEF.md
# Host Register Bridge with Direct and Indirect Addressing

This block is the slave end of an SRAM-style parallel host bus. It turns chip-select, read-strobe and write-strobe activity into single-cycle register read and write pulses on an internal 16-bit register port. The logic behind that port holds the actual registers, FIFO windows and buffer memory. Every access the bridge passes through produces exactly one pulse, so a FIFO-window register behind it advances once per host word.

The bridge supports two addressing methods. In direct addressing, the host address selects the register offset. In indirect addressing, the host loads a target offset into an address register and then reaches that offset through a data window. The offset stays in place across any number of data accesses, so a FIFO burst needs no further address writes. The bridge owns a small control register. Its bits enable indirect addressing, drive a memory-test flag to the core, and trigger a soft reset.

With `byte_mode` high, only the low eight data lines are used and each 16-bit register occupies two byte addresses. Writes are staged until the second byte arrives. Reads fetch the whole word on the first byte and keep the second byte for later.

Top module: `host_reg_bridge`

## Requirements
- R1: After reset `hdout` is 0, `hd_oe`, `reg_rd`, `reg_wr`, `core_rst` and `mem_test` are 0, addressing is direct, and the indirect address register is 0.
- R2: In direct addressing, a 16-bit host access to any word offset other than 0x000 gives exactly one `reg_wr` (carrying `hdin`) or one `reg_rd` pulse. The pulse address is the host address with bit 0 cleared. A read returns `reg_rdata` on `hdout`.
- R3: The control register sits at host offset 0x000 in both addressing methods. Bit 0 selects indirect addressing and bit 5 drives `mem_test`. Both bits read back, and all other bits read 0.
- R4: Writing the control register with bit 7 set pulses `core_rst` for one cycle. It clears bits 0 and 5 and the indirect address register, and bit 7 reads back as 0.
- R5: In indirect addressing, offset 0x002 is the address register, which can be read back. Every access to the data window at 0x004 pulses the port at the word offset held there. The held offset does not change across data accesses, so repeated reads pop a FIFO window once each.
- R6: In indirect addressing, a host access to any offset other than 0x000, 0x002 and 0x004 produces no port pulse, and a read of such an offset returns 0.
- R7: With `byte_mode` high, host address bit 0 picks the byte lane: 0 is the high byte and 1 is the low byte. This holds for the control register, the address register and the data window. Read data appears on `hdout[7:0]` with `hdout[15:8]` at 0.
- R8: A byte-mode write to byte 0 of a passed-through register produces no pulse. The following write to byte 1 produces one `reg_wr` carrying {byte 0, byte 1}.
- R9: A byte-mode read of byte 0 of a passed-through register produces one `reg_rd` and returns the high byte. A read of byte 1 then returns the low byte of that same word with no further pulse.
- R10: If a write to the address register completes in the same cycle that a read of the data window starts, the read uses the newly written offset.
- R11: `hd_oe` is high exactly while both `cs_n` and `rd_n` are low. Read data is captured on the falling read strobe.
- R12: Strobes given while `cs_n` is high cause no pulse and change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bridge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_mode | input | 1 | 1: 8-bit host data, 0: 16-bit |
| cs_n | input | 1 | Host chip select, active low |
| rd_n | input | 1 | Host read strobe, active low |
| wr_n | input | 1 | Host write strobe, active low |
| haddr | input | AW | Host byte address |
| hdin | input | 16 | Host write data |
| hdout | output | 16 | Host read data |
| hd_oe | output | 1 | Read data drive enable |
| reg_rd | output | 1 | Internal register read pulse |
| reg_raddr | output | AW | Internal read word offset |
| reg_rdata | input | 16 | Internal read data, valid during `reg_rd` |
| reg_wr | output | 1 | Internal register write pulse |
| reg_waddr | output | AW | Internal write word offset |
| reg_wdata | output | 16 | Internal write data |
| core_rst | output | 1 | Soft reset pulse to the register core |
| mem_test | output | 1 | Memory-test flag to the core |

## Verification
A completing write and a starting read can land in the same cycle. This happens when the host releases the write strobe and drops the read strobe at the same moment with chip-select held low. The bench provokes this by writing the address register and, in the same clock period, starting a read of the data window. It judges the outcome by checking that the single read pulse carries the new offset and that the returned word matches the bench's model of the core at that offset.

// File: rtl/host_reg_bridge.sv
module host_reg_bridge #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_mode,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [AW-1:0] haddr,
  input  logic [15:0]   hdin,
  output logic [15:0]   hdout,
  output logic          hd_oe,
  output logic          reg_rd,
  output logic [AW-1:0] reg_raddr,
  input  logic [15:0]   reg_rdata,
  output logic          reg_wr,
  output logic [AW-1:0] reg_waddr,
  output logic [15:0]   reg_wdata,
  output logic          core_rst,
  output logic          mem_test
);
  localparam logic [AW-1:0] OFS_CTL = AW'(0);
  localparam logic [AW-1:0] OFS_PTR = AW'(2);
  localparam logic [AW-1:0] OFS_WIN = AW'(4);

  logic rd1, rd2, wr1, wr2, cs1, wv;
  logic [AW-1:0] ha_q, wa;
  logic [15:0] wd, dout;
  logic [7:0] wstage, rstage;
  logic ind, mt;
  logic [AW-1:0] iar;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd1 <= 1'b1; rd2 <= 1'b1; wr1 <= 1'b1; wr2 <= 1'b1; cs1 <= 1'b1;
      ha_q <= '0;
    end else begin
      rd1 <= rd_n; rd2 <= rd1; wr1 <= wr_n; wr2 <= wr1; cs1 <= cs_n;
      ha_q <= haddr;
    end

  wire rfire = rd2 & ~rd1 & ~cs1;
  wire wfire = wr1 & ~wr2 & wv;

  // write side decode
  wire [AW-1:0] w_word = {wa[AW-1:1], 1'b0};
  wire w_lo   = wa[0];
  wire w_ctl  = (w_word == OFS_CTL);
  wire w_ptr  = ind & (w_word == OFS_PTR);
  wire w_win  = ind & (w_word == OFS_WIN);
  wire w_pass = ind ? w_win : ~w_ctl;
  wire [15:0] wval = !byte_mode ? wd : (w_lo ? {8'h00, wd[7:0]} : {wd[7:0], 8'h00});
  wire ctl_lane = ~byte_mode | w_lo;
  wire ctl_wr = wfire & w_ctl & ctl_lane;
  wire srst = ctl_wr & wval[7];

  wire [15:0] iar16 = 16'(iar);
  wire [15:0] iar_w = !byte_mode ? wd : (w_lo ? {iar16[15:8], wd[7:0]} : {wd[7:0], iar16[7:0]});
  wire [AW-1:0] iar_nx = srst ? '0 : ((wfire & w_ptr) ? AW'(iar_w) : iar);
  wire ind_nx = srst ? 1'b0 : (ctl_wr ? wval[0] : ind);
  wire mt_nx  = srst ? 1'b0 : (ctl_wr ? wval[5] : mt);

  assign reg_wr    = wfire & w_pass & (~byte_mode | w_lo);
  assign reg_waddr = w_win ? {iar[AW-1:1], 1'b0} : w_word;
  assign reg_wdata = byte_mode ? {wstage, wd[7:0]} : wd;
  assign core_rst  = srst;
  assign mem_test  = mt;

  // read side decode, with the pending write forwarded
  wire [AW-1:0] r_word = {ha_q[AW-1:1], 1'b0};
  wire r_lo   = ha_q[0];
  wire r_ctl  = (r_word == OFS_CTL);
  wire r_ptr  = ind_nx & (r_word == OFS_PTR);
  wire r_win  = ind_nx & (r_word == OFS_WIN);
  wire r_pass = ind_nx ? r_win : ~r_ctl;
  wire [15:0] rloc = r_ctl ? {10'd0, mt_nx, 4'd0, ind_nx} : (r_ptr ? 16'(iar_nx) : 16'h0000);

  assign reg_rd    = rfire & r_pass & (~byte_mode | ~r_lo);
  assign reg_raddr = r_win ? {iar_nx[AW-1:1], 1'b0} : r_word;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wa <= '0; wd <= '0; wv <= 1'b0;
      ind <= 1'b0; mt <= 1'b0; iar <= '0;
      wstage <= '0; rstage <= '0; dout <= '0;
    end else begin
      if (!cs_n && !wr_n) begin
        wa <= haddr; wd <= hdin; wv <= 1'b1;
      end else if (wfire) wv <= 1'b0;
      ind <= ind_nx; mt <= mt_nx; iar <= iar_nx;
      if (srst) begin
        wstage <= '0; rstage <= '0;
      end else if (wfire & w_pass & byte_mode & ~w_lo) wstage <= wd[7:0];
      if (rfire) begin
        if (!byte_mode) dout <= r_pass ? reg_rdata : rloc;
        else if (r_pass) begin
          if (!r_lo) begin
            dout <= {8'h00, reg_rdata[15:8]};
            rstage <= reg_rdata[7:0];
          end else dout <= {8'h00, rstage};
        end else dout <= {8'h00, r_lo ? rloc[7:0] : rloc[15:8]};
      end
    end

  assign hdout = dout;
  assign hd_oe = ~cs_n & ~rd_n;

  // R2
  reg_wr_once_chk: assert property (@(posedge clk) disable iff (!rst_n) reg_wr |=> !reg_wr);
  // R9
  reg_rd_once_chk: assert property (@(posedge clk) disable iff (!rst_n) reg_rd |=> !reg_rd);
  // R4
  soft_rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |=> (iar == '0 && !mem_test && !ind));
  // R5
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !wfire |=> $stable(iar));
  // R3
  mt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !wfire |=> $stable(mem_test));
endmodule

// File: tb/host_reg_bridge_test.sv
`timescale 1ns/1ps
module host_reg_bridge_test;
  localparam int AW = 10;
  logic clk = 1'b0, rst_n = 1'b0, byte_mode = 1'b0;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [AW-1:0] haddr = '0;
  logic [15:0] hdin = '0;
  logic [15:0] hdout, reg_rdata, reg_wdata;
  logic hd_oe, reg_rd, reg_wr, core_rst, mem_test;
  logic [AW-1:0] reg_raddr, reg_waddr;

  int vectors = 0, miscompares = 0;
  int rd_cnt = 0, wr_cnt = 0, rst_cnt = 0;
  logic [AW-1:0] last_raddr = '0, last_waddr = '0;
  logic [15:0] last_wdata = '0;
  bit done = 0;

  always #5 clk = ~clk;

  host_reg_bridge #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .byte_mode(byte_mode), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .haddr(haddr), .hdin(hdin), .hdout(hdout), .hd_oe(hd_oe),
    .reg_rd(reg_rd), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .reg_wr(reg_wr), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
    .core_rst(core_rst), .mem_test(mem_test));

  function automatic logic [15:0] core_word(logic [AW-1:0] a, int n);
    return {a[7:0] ^ 8'h5A, 8'(n)};
  endfunction

  assign reg_rdata = core_word(reg_raddr, rd_cnt);

  always @(posedge clk) begin
    if (reg_rd) begin rd_cnt <= rd_cnt + 1; last_raddr <= reg_raddr; end
    if (reg_wr) begin wr_cnt <= wr_cnt + 1; last_waddr <= reg_waddr; last_wdata <= reg_wdata; end
    if (core_rst) rst_cnt <= rst_cnt + 1;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hwr(logic [AW-1:0] a, logic [15:0] d, bit cs = 1);
    @(negedge clk); cs_n = !cs; haddr = a; hdin = d; wr_n = 1'b0;
    repeat (2) @(negedge clk); wr_n = 1'b1; cs_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic hrd(logic [AW-1:0] a, output logic [15:0] d, output logic oe, input bit cs = 1);
    @(negedge clk); cs_n = !cs; haddr = a; rd_n = 1'b0;
    repeat (3) @(negedge clk); d = hdout; oe = hd_oe;
    rd_n = 1'b1; cs_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      vectors++; miscompares++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [15:0] d, e; logic oe; int n, w0; logic [AW-1:0] a; logic [7:0] hb, lb;
    w0 = $urandom(32'h5EED);
    repeat (3) @(negedge clk); rst_n = 1'b1; @(negedge clk);
    // R1
    chk("R1 hdout", hdout, 0); chk("R1 oe", hd_oe, 0); chk("R1 mem_test", mem_test, 0);
    chk("R1 pulses", rd_cnt + wr_cnt + rst_cnt, 0);

    // R2 random direct accesses
    for (int i = 0; i < 40; i++) begin
      a = {AW'($urandom_range(1, 511)) << 1};
      d = 16'($urandom);
      w0 = wr_cnt; hwr(a, d);
      chk("R2 wr count", wr_cnt, w0 + 1); chk("R2 waddr", last_waddr, a); chk("R2 wdata", last_wdata, d);
      n = rd_cnt; hrd(a | AW'($urandom_range(0, 1)), d, oe);
      chk("R2 rdata", d, core_word(a, n)); chk("R2 raddr", last_raddr, a);
      chk("R11 oe", oe, 1);
    end

    // R3
    hwr(0, 16'h0020); chk("R3 mem_test", mem_test, 1);
    hrd(0, d, oe); chk("R3 readback", d, 16'h0020);
    hwr(0, 16'h0061); hrd(0, d, oe); chk("R3 other bits 0", d, 16'h0021);

    // R5 indirect
    hwr(2, 16'h0270); hrd(2, d, oe); chk("R5 ptr readback", d, 16'h0270);
    w0 = wr_cnt; hwr(4, 16'h1234);
    chk("R5 wr count", wr_cnt, w0 + 1); chk("R5 waddr", last_waddr, 10'h270); chk("R5 wdata", last_wdata, 16'h1234);
    for (int i = 0; i < 6; i++) begin
      n = rd_cnt; hrd(4, d, oe);
      chk("R5 burst data", d, core_word(10'h270, n)); chk("R5 burst count", rd_cnt, n + 1);
      chk("R5 burst addr", last_raddr, 10'h270);
    end
    hrd(2, d, oe); chk("R5 ptr held", d, 16'h0270);

    // R6
    w0 = wr_cnt; n = rd_cnt; hwr(10'h100, 16'hBEEF); hrd(10'h100, d, oe);
    chk("R6 no wr", wr_cnt, w0); chk("R6 no rd", rd_cnt, n); chk("R6 read 0", d, 0);

    // R12
    w0 = wr_cnt; hwr(4, 16'h5555, 0); chk("R12 no wr", wr_cnt, w0);
    hwr(0, 16'h0080, 0); chk("R12 no reset", rst_cnt, 0); chk("R12 mem_test kept", mem_test, 1);
    n = rd_cnt; hrd(4, d, oe, 0); chk("R12 no rd", rd_cnt, n); chk("R11 oe without cs", oe, 0);

    // R10 same-cycle ptr write and window read
    @(negedge clk); cs_n = 1'b0; haddr = 2; hdin = 16'h0340; wr_n = 1'b0;
    repeat (2) @(negedge clk); n = rd_cnt; wr_n = 1'b1; haddr = 4; rd_n = 1'b0;
    repeat (3) @(negedge clk); d = hdout; rd_n = 1'b1; cs_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 raddr", last_raddr, 10'h340); chk("R10 data", d, core_word(10'h340, n));
    chk("R10 one pulse", rd_cnt, n + 1);

    // R4
    hwr(0, 16'h0080); chk("R4 pulse", rst_cnt, 1); chk("R4 mem_test", mem_test, 0);
    hrd(0, d, oe); chk("R4 ctl 0", d, 0);
    n = rd_cnt; hrd(2, d, oe); chk("R4 direct again", rd_cnt, n + 1);
    hwr(0, 16'h0001); hrd(2, d, oe); chk("R4 ptr cleared", d, 0);

    // R7 R8 R9 byte mode, indirect
    byte_mode = 1'b1;
    hrd(1, d, oe); chk("R7 ctl low byte", d, 16'h0001);
    hrd(0, d, oe); chk("R7 ctl high byte", d, 0);
    hwr(2, 16'h0002); hwr(3, 16'h0070);
    hrd(2, d, oe); chk("R7 ptr high", d, 16'h0002);
    hrd(3, d, oe); chk("R7 ptr low", d, 16'h0070);
    w0 = wr_cnt; hwr(4, 16'h00AB); chk("R8 no pulse byte0", wr_cnt, w0);
    hwr(5, 16'h00CD); chk("R8 one pulse", wr_cnt, w0 + 1);
    chk("R8 wdata", last_wdata, 16'hABCD); chk("R8 waddr", last_waddr, 10'h270);
    for (int i = 0; i < 4; i++) begin
      n = rd_cnt; e = core_word(10'h270, n);
      hrd(4, d, oe); chk("R9 high byte", d, {8'h00, e[15:8]});
      hrd(5, d, oe); chk("R9 low byte", d, {8'h00, e[7:0]});
      chk("R9 one pulse", rd_cnt, n + 1);
    end

    // R8 R9 byte mode, direct, random
    hwr(1, 16'h0000);
    for (int i = 0; i < 20; i++) begin
      a = {AW'($urandom_range(1, 511)) << 1};
      hb = 8'($urandom); lb = 8'($urandom);
      w0 = wr_cnt; hwr(a, {8'h00, hb}); chk("R8 staged", wr_cnt, w0);
      hwr(a | 1, {8'h00, lb});
      chk("R8 word", last_wdata, {hb, lb}); chk("R8 addr", last_waddr, a);
      n = rd_cnt; e = core_word(a, n);
      hrd(a, d, oe); chk("R9 hi", d, {8'h00, e[15:8]});
      hrd(a | 1, d, oe); chk("R9 lo", d, {8'h00, e[7:0]});
      chk("R9 count", rd_cnt, n + 1);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule